// File: doc/BRIEF.md
# Per-CPU Private Peripheral Address Decoder

This block sits on a simple register bus in front of the private peripherals of a small multiprocessor cluster. It covers a 4 KB window. Every access carries an address, write data, a write enable, a read enable and the index of the CPU that issues it. The block steers each access to one of three targets. The first is a small snoop-control register file, which the block holds itself. The second is a banked interrupt-controller CPU-interface port. The third is a banked timer/watchdog port. The two external targets receive a one-cycle write or read strobe, a CPU bank index and a local offset. Their read data comes back into the block in the same cycle.

Each banked range has two parts. The first is an alias window, which resolves to the bank of the requesting CPU. The second is a set of explicitly indexed windows, one per CPU. Writes whose bank index is at or above the configured CPU count are dropped. Reads that cannot be served return zero and raise a one-cycle error. The configuration register is built from the CPU count parameter.

Top module: `cpu_priv_window`

## Requirements
- R1: Offsets 0x000–0x0FF reach the snoop registers. A write to 0x000 stores only write-data bit 0. A read of 0x000 returns that bit with all other bits zero.
- R2: A read of 0x004 returns ones in bits [4+N-1:4] ORed with N-1, where N is the CPU count (0x72 for N=3). Reads of 0x008 and 0x00C return zero. A write to 0x00C leaves the stored control bit unchanged.
- R3: Offsets 0x100–0x1FF raise the interrupt-interface strobe, which matches the bus enable (write or read). The bank index equals the requesting CPU, the local offset is address bits [7:0], and the timer strobes stay low.
- R4: Offsets 0x200–0x5FF raise the interrupt-interface strobe with bank index (address − 0x200) >> 8 and local offset address bits [7:0].
- R5: Offsets 0x600–0x6FF raise the timer strobe for the requesting CPU's bank, with register offset address bits [3:0]. The interrupt strobes stay low.
- R6: Offsets 0x700–0xAFF raise the timer strobe with bank index (address − 0x700) >> 8 and register offset address bits [3:0].
- R7: Whenever the resolved bank index (explicit or alias) is at or above N, no write strobe reaches any bank.
- R8: A read is unserved when any of these holds: the resolved bank index is at or above N; the offset is 0x000–0x0FF but not 0x000, 0x004, 0x008 or 0x00C; or the offset is 0xB00 or higher. An unserved read returns zero and asserts err_o for exactly one cycle.
- R9: rdata_o and err_o are registered and change in the cycle after the read enable. External read data is sampled in the read-enable cycle. After reset both outputs are zero.
- R10: When write and read enables are both high in one cycle, the read returns the value held before the write. Both strobes of the addressed bank are raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Byte offset within the window |
| cpu_id_i | input | IDX_W | Index of the requesting CPU |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| err_o | output | 1 | One-cycle pulse for an unserved read |
| irq_wr_o | output | 1 | Interrupt-interface write strobe |
| irq_rd_o | output | 1 | Interrupt-interface read strobe |
| irq_cpu_o | output | IDX_W | Interrupt-interface bank index |
| irq_off_o | output | 8 | Interrupt-interface local offset |
| irq_rdata_i | input | DATA_W | Interrupt-interface read data |
| tmr_wr_o | output | 1 | Timer/watchdog write strobe |
| tmr_rd_o | output | 1 | Timer/watchdog read strobe |
| tmr_cpu_o | output | IDX_W | Timer/watchdog bank index |
| tmr_off_o | output | 4 | Timer/watchdog register offset |
| tmr_rdata_i | input | DATA_W | Timer/watchdog read data |

## Verification
A write and a read can land in the same cycle. The bench provokes this by asserting both enables at once. On the control register, it clears the bit and then issues a combined write-read of 1. The read must return 0, and a later plain read must return 1. On an interrupt-interface offset, the same combined access must raise the write and read strobes together and return that bank's data.

// File: rtl/priv_win_pkg.sv
package priv_win_pkg;
  localparam int WIN_AW = 12;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_SNOOP,
    TGT_IRQ,
    TGT_TMR
  } tgt_e;

  localparam logic [WIN_AW-1:0] IRQ_BASE = 12'h100;
  localparam logic [WIN_AW-1:0] IRQ_BANK = 12'h200;
  localparam logic [WIN_AW-1:0] TMR_BASE = 12'h600;
  localparam logic [WIN_AW-1:0] TMR_BANK = 12'h700;
  localparam logic [WIN_AW-1:0] WIN_END  = 12'hB00;

  localparam logic [3:0] IRQ_PAGE0 = 4'd2;
  localparam logic [3:0] TMR_PAGE0 = 4'd7;
endpackage

// File: rtl/priv_addr_decode.sv
module priv_addr_decode
  import priv_win_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int IDX_W    = 2
) (
  input  logic [WIN_AW-1:0] addr_i,
  input  logic [IDX_W-1:0]  cpu_id_i,
  output tgt_e              tgt_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              idx_ok_o,
  output logic [7:0]        off_o
);
  localparam logic [3:0] NCPU = 4'(NUM_CPUS);

  logic [3:0] page;
  logic [3:0] idx_full;

  assign page = addr_i[11:8];

  always_comb begin
    tgt_o    = TGT_NONE;
    idx_full = '0;
    if (addr_i < IRQ_BASE) begin
      tgt_o = TGT_SNOOP;
    end else if (addr_i < TMR_BASE) begin
      tgt_o    = TGT_IRQ;
      idx_full = (addr_i < IRQ_BANK) ? 4'(cpu_id_i) : page - IRQ_PAGE0;
    end else if (addr_i < WIN_END) begin
      tgt_o    = TGT_TMR;
      idx_full = (addr_i < TMR_BANK) ? 4'(cpu_id_i) : page - TMR_PAGE0;
    end
  end

  assign idx_ok_o = (idx_full < NCPU);
  assign idx_o    = idx_full[IDX_W-1:0];
  assign off_o    = addr_i[7:0];
endmodule

// File: rtl/snoop_regs.sv
module snoop_regs #(
  parameter int NUM_CPUS = 4,
  parameter int DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        off_i,
  input  logic              wbit_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              hit_o
);
  localparam logic [DATA_W-1:0] CFG_VAL =
    DATA_W'((((1 << NUM_CPUS) - 1) << 4) | (NUM_CPUS - 1));

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_CFG  = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h08;
  localparam logic [7:0] OFF_INV  = 8'h0C;

  logic ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ctrl_q <= 1'b0;
    else if (wr_i && off_i == OFF_CTRL)  ctrl_q <= wbit_i;
  end

  always_comb begin
    rdata_o = '0;
    hit_o   = 1'b1;
    unique case (off_i)
      OFF_CTRL: rdata_o = DATA_W'(ctrl_q);
      OFF_CFG:  rdata_o = CFG_VAL;
      OFF_STAT: rdata_o = '0;
      OFF_INV:  rdata_o = '0;
      default:  hit_o   = 1'b0;
    endcase
  end

  // R2
  inv_noop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && off_i == OFF_INV) |=> $stable(ctrl_q));

  // R1
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_q));
endmodule

// File: rtl/priv_rdata_reg.sv
module priv_rdata_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              miss_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= re_i & miss_i;
      if (re_i) rdata_o <= miss_i ? '0 : data_i;
    end
  end

  // R8
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));

  // R9
  err_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(re_i));
endmodule

// File: rtl/cpu_priv_window.sv
module cpu_priv_window
  import priv_win_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [11:0]       addr_i,
  input  logic [IDX_W-1:0]  cpu_id_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              irq_wr_o,
  output logic              irq_rd_o,
  output logic [IDX_W-1:0]  irq_cpu_o,
  output logic [7:0]        irq_off_o,
  input  logic [DATA_W-1:0] irq_rdata_i,
  output logic              tmr_wr_o,
  output logic              tmr_rd_o,
  output logic [IDX_W-1:0]  tmr_cpu_o,
  output logic [3:0]        tmr_off_o,
  input  logic [DATA_W-1:0] tmr_rdata_i
);
  localparam logic [DATA_W-1:0] CFG_EXP =
    DATA_W'((((1 << NUM_CPUS) - 1) << 4) | (NUM_CPUS - 1));

  tgt_e              tgt;
  logic [IDX_W-1:0]  idx;
  logic              idx_ok;
  logic [7:0]        off;
  logic [DATA_W-1:0] snoop_rdata;
  logic              snoop_hit;
  logic              irq_go, tmr_go, snoop_wr;
  logic [DATA_W-1:0] rd_mux;
  logic              rd_miss;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:1];

  priv_addr_decode #(.NUM_CPUS(NUM_CPUS), .IDX_W(IDX_W)) u_decode (
    .addr_i   (addr_i),
    .cpu_id_i (cpu_id_i),
    .tgt_o    (tgt),
    .idx_o    (idx),
    .idx_ok_o (idx_ok),
    .off_o    (off)
  );

  assign snoop_wr = we_i && (tgt == TGT_SNOOP);
  assign irq_go   = (tgt == TGT_IRQ) && idx_ok;
  assign tmr_go   = (tgt == TGT_TMR) && idx_ok;

  snoop_regs #(.NUM_CPUS(NUM_CPUS), .DATA_W(DATA_W)) u_snoop (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (snoop_wr),
    .off_i   (off),
    .wbit_i  (wdata_i[0]),
    .rdata_o (snoop_rdata),
    .hit_o   (snoop_hit)
  );

  assign irq_wr_o  = we_i && irq_go;
  assign irq_rd_o  = re_i && irq_go;
  assign irq_cpu_o = idx;
  assign irq_off_o = off;
  assign tmr_wr_o  = we_i && tmr_go;
  assign tmr_rd_o  = re_i && tmr_go;
  assign tmr_cpu_o = idx;
  assign tmr_off_o = off[3:0];

  always_comb begin
    rd_mux  = '0;
    rd_miss = 1'b1;
    unique case (tgt)
      TGT_SNOOP: begin rd_mux = snoop_rdata; rd_miss = !snoop_hit; end
      TGT_IRQ:   begin rd_mux = irq_rdata_i; rd_miss = !idx_ok;    end
      TGT_TMR:   begin rd_mux = tmr_rdata_i; rd_miss = !idx_ok;    end
      default:   begin rd_mux = '0;          rd_miss = 1'b1;       end
    endcase
  end

  priv_rdata_reg #(.DATA_W(DATA_W)) u_rret (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .re_i    (re_i),
    .data_i  (rd_mux),
    .miss_i  (rd_miss),
    .rdata_o (rdata_o),
    .err_o   (err_o)
  );

  // R7
  irq_bank_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_wr_o |-> (32'(irq_cpu_o) < NUM_CPUS));

  // R7
  tmr_bank_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_wr_o |-> (32'(tmr_cpu_o) < NUM_CPUS));

  // R3
  tgt_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((irq_wr_o || irq_rd_o) && (tmr_wr_o || tmr_rd_o)));

  // R2
  cfg_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == 12'h004) |=> (rdata_o == CFG_EXP));
endmodule

// File: tb/cpu_priv_window_bench.sv
module cpu_priv_window_bench;
  localparam int N  = 3;
  localparam int DW = 32;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   addr = '0;
  logic [IW-1:0] cpu = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          err;
  logic          irq_wr, irq_rd, tmr_wr, tmr_rd;
  logic [IW-1:0] irq_cpu, tmr_cpu;
  logic [7:0]    irq_off;
  logic [3:0]    tmr_off;
  logic [DW-1:0] irq_rdata, tmr_rdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // target models: echo bank and offset
  assign irq_rdata = {16'hC1C1, 6'd0, irq_cpu, irq_off};
  assign tmr_rdata = {16'h7E7E, 10'd0, tmr_cpu, tmr_off};

  cpu_priv_window #(.NUM_CPUS(N), .DATA_W(DW)) u_cpu_priv_window (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .cpu_id_i(cpu),
    .we_i(we), .re_i(re), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .irq_wr_o(irq_wr), .irq_rd_o(irq_rd), .irq_cpu_o(irq_cpu),
    .irq_off_o(irq_off), .irq_rdata_i(irq_rdata),
    .tmr_wr_o(tmr_wr), .tmr_rd_o(tmr_rd), .tmr_cpu_o(tmr_cpu),
    .tmr_off_o(tmr_off), .tmr_rdata_i(tmr_rdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(logic [11:0] a, logic [IW-1:0] id, logic w, logic r,
                     logic [31:0] wd);
    @(negedge clk);
    addr = a; cpu = id; we = w; re = r; wdata = wd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R9 reset rdata", rdata, 32'h0);
    chk("R9 reset err", {31'b0, err}, 32'h0);
  endtask

  task automatic t_snoop();
    put(12'h000, 0, 1, 0, 32'hFFFF_FFFF); idle();
    put(12'h000, 0, 0, 1, 0); idle();
    chk("R1 ctrl keeps bit0", rdata, 32'h1);
    put(12'h000, 0, 1, 0, 32'hFFFF_FFFE); idle();
    put(12'h000, 0, 0, 1, 0); idle();
    chk("R1 ctrl cleared", rdata, 32'h0);
    put(12'h000, 0, 1, 0, 32'h1); idle();
    put(12'h00C, 0, 1, 0, 32'h0); idle();
    put(12'h000, 0, 0, 1, 0); idle();
    chk("R2 invalidate no effect", rdata, 32'h1);
    put(12'h004, 0, 0, 1, 0); idle();
    chk("R2 config", rdata, 32'h72);
    put(12'h008, 0, 0, 1, 0); idle();
    chk("R2 status zero", rdata, 32'h0);
    chk("R2 status no err", {31'b0, err}, 32'h0);
  endtask

  task automatic t_irq_alias();
    put(12'h140, 2, 0, 1, 0);
    chk("R3 irq rd strobe", {30'b0, irq_rd, tmr_rd}, 32'h2);
    chk("R3 irq cpu", 32'(irq_cpu), 32'd2);
    chk("R3 irq off", 32'(irq_off), 32'h40);
    idle();
    chk("R3 irq rdata", rdata, 32'hC1C1_0240);
    put(12'h1A8, 1, 1, 0, 32'h55);
    chk("R3 irq wr strobe", {29'b0, irq_wr, irq_rd, tmr_wr}, 32'h4);
    chk("R3 irq wr cpu", 32'(irq_cpu), 32'd1);
    idle();
  endtask

  task automatic t_irq_bank();
    put(12'h310, 0, 0, 1, 0);
    chk("R4 bank1 strobe", {31'b0, irq_rd}, 32'h1);
    chk("R4 bank1 cpu", 32'(irq_cpu), 32'd1);
    idle();
    chk("R4 bank1 rdata", rdata, 32'hC1C1_0110);
    put(12'h2FC, 2, 1, 0, 32'h9);
    chk("R4 bank0 cpu", 32'(irq_cpu), 32'd0);
    chk("R4 bank0 off", 32'(irq_off), 32'hFC);
    chk("R4 bank0 wr", {31'b0, irq_wr}, 32'h1);
    idle();
  endtask

  task automatic t_tmr_alias();
    put(12'h60C, 1, 0, 1, 0);
    chk("R5 tmr strobe", {30'b0, tmr_rd, irq_rd}, 32'h2);
    chk("R5 tmr cpu", 32'(tmr_cpu), 32'd1);
    chk("R5 tmr off", 32'(tmr_off), 32'hC);
    idle();
    chk("R5 tmr rdata", rdata, 32'h7E7E_001C);
    put(12'h628, 0, 1, 0, 32'h3);
    chk("R5 tmr wr off", 32'(tmr_off), 32'h8);
    chk("R5 tmr wr", {31'b0, tmr_wr}, 32'h1);
    idle();
  endtask

  task automatic t_tmr_bank();
    put(12'h904, 0, 0, 1, 0);
    chk("R6 bank2 cpu", 32'(tmr_cpu), 32'd2);
    chk("R6 bank2 off", 32'(tmr_off), 32'h4);
    idle();
    chk("R6 bank2 rdata", rdata, 32'h7E7E_0024);
  endtask

  task automatic t_range();
    put(12'h504, 0, 1, 0, 32'h1);
    chk("R7 irq bank3 write dropped", {31'b0, irq_wr}, 32'h0);
    put(12'hA00, 0, 1, 0, 32'h1);
    chk("R7 tmr bank3 write dropped", {31'b0, tmr_wr}, 32'h0);
    put(12'h100, 3, 1, 0, 32'h1);
    chk("R7 alias cpu3 write dropped", {31'b0, irq_wr}, 32'h0);
    idle();
    put(12'h500, 0, 0, 1, 0);
    chk("R8 no rd strobe", {31'b0, irq_rd}, 32'h0);
    idle();
    chk("R8 oob rdata", rdata, 32'h0);
    chk("R8 oob err", {31'b0, err}, 32'h1);
    idle();
    chk("R8 err one cycle", {31'b0, err}, 32'h0);
    put(12'hB00, 0, 0, 1, 0); idle();
    chk("R8 past end err", {31'b0, err}, 32'h1);
    put(12'h010, 0, 0, 1, 0); idle();
    chk("R8 snoop hole err", {31'b0, err}, 32'h1);
    put(12'h604, 3, 0, 1, 0); idle();
    chk("R8 alias cpu3 err", {31'b0, err}, 32'h1);
    idle();
  endtask

  task automatic t_latency();
    put(12'h004, 0, 0, 1, 0);
    put(12'h008, 0, 0, 1, 0);
    chk("R9 first read out", rdata, 32'h72);
    idle();
    chk("R9 second read out", rdata, 32'h0);
  endtask

  task automatic t_collide();
    put(12'h000, 0, 1, 0, 32'h0); idle();
    put(12'h000, 0, 1, 1, 32'h1); idle();
    chk("R10 read sees old ctrl", rdata, 32'h0);
    put(12'h000, 0, 0, 1, 0); idle();
    chk("R10 write landed", rdata, 32'h1);
    put(12'h220, 2, 1, 1, 32'h7);
    chk("R10 both strobes", {30'b0, irq_wr, irq_rd}, 32'h3);
    idle();
    chk("R10 combined rdata", rdata, 32'hC1C1_0020);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_snoop();
    t_irq_alias();
    t_irq_bank();
    t_tmr_alias();
    t_tmr_bank();
    t_range();
    t_latency();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule